// File: doc/BRIEF.md
# One-Hot Pointer Push-Down Stack

This block is a last-in first-out store for the operand or return stack of a stack-machine core. It holds sixteen 18-bit entries. The newest entry sits in a dedicated top register, so it is always available without a RAM read. The entries beneath it live in a 16-slot register array. A one-hot ring pointer selects the array slot that holds the second entry. The pointer rotates one way on a push and the other way on a pop, so each push or pop finishes in a single clock cycle.

The core drives one of three strobes on a cycle: push, pop or replace-top. Both the top entry and the second entry are visible on outputs at all times. The second entry is read combinationally through the pointer. Overflow and underflow are not detected. The pointer wraps around the ring, and a push past sixteen entries silently overwrites the oldest slot. Software that keeps its depth within bounds sees an exact stack. Software that does not sees a circular buffer.

Top module: `onehot_lifo`

## Requirements
- R1: After reset, top_o is zero and the pointer marks slot 0. The first push therefore writes the old top value, zero, into slot 1, and next_o reads 0 on the following cycle.
- R2: A push (push_i high) loads wr_data_i into the top register. The previous top value becomes visible on next_o on the cycle after the clock edge.
- R3: The internal pointer always has exactly one bit set. It rotates towards higher slot numbers on a push and towards lower slot numbers on a pop, wrapping between slot 15 and slot 0.
- R4: A pop (pop_i high, push_i low) loads the top register with the value shown on next_o before the edge. After the edge, next_o shows the entry that lay one below it.
- R5: A replace-top (set_top_i high, push_i and pop_i low) loads wr_data_i into the top register. next_o keeps its value.
- R6: When several strobes are high in the same cycle, push takes precedence over pop, and pop takes precedence over replace-top. The strobes that lose have no effect.
- R7: On a cycle with no strobe high, top_o and next_o keep their values.
- R8: The 17th push in a row overwrites the oldest stored entry without any error indication. After 20 pushes of v1..v20, 16 pops return v19 down to v4. A 17th pop then returns v19 again.
- R9: next_o follows the slot under the pointer combinationally. It changes in the same cycle in which the pointer or that slot changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Push wr_data_i onto the stack |
| pop_i | input | 1 | Discard the top entry |
| set_top_i | input | 1 | Overwrite the top entry with wr_data_i |
| wr_data_i | input | 18 | Data for push and replace-top |
| top_o | output | 18 | Current top entry |
| next_o | output | 18 | Entry directly below the top |

## Verification
The hardest state to reach is the wrapped ring. In that state, slots written before the wrap have been overwritten, and the pointer has crossed the boundary between slot 15 and slot 0 in both directions. The bench drives twenty consecutive pushes of distinct values and then seventeen pops. A reference model of the ring and the slots predicts every top and second entry along the way. The final pop lands on a slot that was overwritten late, which shows that the wrap is silent and exact. The combined-strobe cycles are handled the same way: they are driven directly, and the model applies the same precedence order.

// File: rtl/lifo_pkg.sv
package lifo_pkg;
    localparam int unsigned LIFO_WIDTH = 18;
    localparam int unsigned LIFO_DEPTH = 16;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_SET  = 2'd3
    } lifo_op_e;

    // Resolve simultaneous strobes: push beats pop, pop beats replace-top.
    function automatic lifo_op_e lifo_decode(input logic push, input logic pop, input logic set_top);
        if (push)         return OP_PUSH;
        else if (pop)     return OP_POP;
        else if (set_top) return OP_SET;
        else              return OP_IDLE;
    endfunction
endpackage

// File: rtl/lifo_ptr_ring.sv
module lifo_ptr_ring #(
    parameter int unsigned DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fwd_i,
    input  logic             back_i,
    output logic [DEPTH-1:0] ptr_q,
    output logic [DEPTH-1:0] ptr_d
);
    localparam logic [DEPTH-1:0] PTR_RESET = {{(DEPTH-1){1'b0}}, 1'b1};

    always_comb begin
        ptr_d = ptr_q;
        if (fwd_i)
            ptr_d = {ptr_q[DEPTH-2:0], ptr_q[DEPTH-1]};
        else if (back_i)
            ptr_d = {ptr_q[0], ptr_q[DEPTH-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= PTR_RESET;
        else        ptr_q <= ptr_d;
    end

    AST_PTR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ptr_q) == 1); // R3
    AST_PTR_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_i |=> ptr_q == {$past(ptr_q[DEPTH-2:0]), $past(ptr_q[DEPTH-1])}); // R3
    AST_PTR_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (back_i && !fwd_i) |=> ptr_q == {$past(ptr_q[0]), $past(ptr_q[DEPTH-1:1])}); // R3
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!back_i && !fwd_i) |=> $stable(ptr_q)); // R5
endmodule

// File: rtl/lifo_slot_ram.sv
module lifo_slot_ram #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WIDTH = 18
) (
    input  logic             clk,
    input  logic             wr_en_i,
    input  logic [DEPTH-1:0] wr_sel_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic [DEPTH-1:0] rd_sel_i,
    output logic [WIDTH-1:0] rd_data_o
);
    logic [WIDTH-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en_i && wr_sel_i[g])
                slot_q[g] <= wr_data_i;
        end
    end

    // One-hot read select: AND-OR mux, no binary decode.
    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < DEPTH; i++)
            rd_data_o = rd_data_o | (slot_q[i] & {WIDTH{rd_sel_i[i]}});
    end

    AST_WSEL_ONEHOT: assert property (@(posedge clk)
        wr_en_i |-> $onehot0(wr_sel_i)); // R3
endmodule

// File: rtl/onehot_lifo.sv
module onehot_lifo
    import lifo_pkg::*;
#(
    parameter int unsigned WIDTH = LIFO_WIDTH,
    parameter int unsigned DEPTH = LIFO_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic             set_top_i,
    input  logic [WIDTH-1:0] wr_data_i,
    output logic [WIDTH-1:0] top_o,
    output logic [WIDTH-1:0] next_o
);
    typedef struct packed {
        logic [WIDTH-1:0] tos;
    } state_t;

    state_t           st_q, st_d;
    lifo_op_e         op;
    logic             adv, ret;
    logic [DEPTH-1:0] ptr_q, ptr_d;
    logic [WIDTH-1:0] below;

    always_comb begin
        op   = lifo_decode(push_i, pop_i, set_top_i);
        adv  = (op == OP_PUSH);
        ret  = (op == OP_POP);
        st_d = st_q;
        unique case (op)
            OP_PUSH: st_d.tos = wr_data_i;
            OP_POP:  st_d.tos = below;
            OP_SET:  st_d.tos = wr_data_i;
            default: st_d.tos = st_q.tos;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    lifo_ptr_ring #(.DEPTH(DEPTH)) i_ring (
        .clk    (clk),
        .rst_n  (rst_n),
        .fwd_i  (adv),
        .back_i (ret),
        .ptr_q  (ptr_q),
        .ptr_d  (ptr_d)
    );

    // On push the old top goes into the slot the pointer moves onto.
    lifo_slot_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_ram (
        .clk       (clk),
        .wr_en_i   (adv),
        .wr_sel_i  (ptr_d),
        .wr_data_i (st_q.tos),
        .rd_sel_i  (ptr_q),
        .rd_data_o (below)
    );

    assign top_o  = st_q.tos;
    assign next_o = below;

    AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> top_o == $past(wr_data_i)); // R2
    AST_PUSH_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> next_o == $past(top_o)); // R2
    AST_POP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> top_o == $past(next_o)); // R4
    AST_SET_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (set_top_i && !pop_i && !push_i) |=> top_o == $past(wr_data_i)); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_top_i && !pop_i && !push_i) |=> $stable(top_o)); // R7
endmodule

// File: tb/test_onehot_lifo.sv
module test_onehot_lifo;
    localparam int W = 18;
    localparam int D = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         push_i = 1'b0, pop_i = 1'b0, set_top_i = 1'b0;
    logic [W-1:0] wr_data_i = '0;
    logic [W-1:0] top_o, next_o;

    int total = 0;
    int bad = 0;

    logic [W-1:0] m_slot [D];
    bit           m_vld  [D];
    int           m_ptr;
    logic [W-1:0] m_top;

    always #10 clk = ~clk;

    onehot_lifo i_onehot_lifo (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
        .set_top_i(set_top_i), .wr_data_i(wr_data_i),
        .top_o(top_o), .next_o(next_o)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ptr = 0;
        m_top = '0;
        for (int i = 0; i < D; i++) m_vld[i] = 1'b0;
    endtask

    // Drive one cycle, update the model by precedence, check both outputs.
    task automatic step(input string req, input bit p, input bit o, input bit s, input logic [W-1:0] d);
        push_i = p; pop_i = o; set_top_i = s; wr_data_i = d;
        @(posedge clk);
        if (p) begin
            m_ptr = (m_ptr + 1) % D;
            m_slot[m_ptr] = m_top;
            m_vld[m_ptr] = 1'b1;
            m_top = d;
        end else if (o) begin
            m_top = m_slot[m_ptr];
            m_ptr = (m_ptr + D - 1) % D;
        end else if (s) begin
            m_top = d;
        end
        #2;
        push_i = 0; pop_i = 0; set_top_i = 0;
        chk(req, top_o, m_top);
        if (m_vld[m_ptr]) chk(req, next_o, m_slot[m_ptr]);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        model_reset();
        repeat (2) @(posedge clk);
        #2 rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 top after reset", top_o, '0);
        step("R1 first push", 1, 0, 0, 18'h00A5A);
        chk("R1 next holds reset top", next_o, '0);
    endtask

    task automatic t_push_pop();
        do_reset();
        step("R2 push", 1, 0, 0, 18'h11111);
        step("R2 push", 1, 0, 0, 18'h22222);
        step("R2 push", 1, 0, 0, 18'h3FFFF);
        chk("R2 next is previous top", next_o, 18'h22222);
        step("R4 pop", 0, 1, 0, 18'h0);
        chk("R4 pop top", top_o, 18'h22222);
        chk("R4 pop next", next_o, 18'h11111);
        step("R4 pop", 0, 1, 0, 18'h0);
        chk("R4 pop top 2", top_o, 18'h11111);
    endtask

    task automatic t_replace_idle();
        logic [W-1:0] nx;
        do_reset();
        step("R5 setup", 1, 0, 0, 18'h00123);
        step("R5 setup", 1, 0, 0, 18'h00456);
        nx = next_o;
        step("R5 replace", 0, 0, 1, 18'h2BEEF);
        chk("R5 replace next unchanged", next_o, nx);
        chk("R5 replace top", top_o, 18'h2BEEF);
        step("R7 idle", 0, 0, 0, 18'h3CAFE);
        chk("R7 idle top", top_o, 18'h2BEEF);
        chk("R7 idle next", next_o, nx);
    endtask

    task automatic t_priority();
        do_reset();
        step("R6 setup", 1, 0, 0, 18'h00001);
        step("R6 push+pop+set", 1, 1, 1, 18'h00002);
        chk("R6 push wins top", top_o, 18'h00002);
        chk("R6 push wins next", next_o, 18'h00001);
        step("R6 pop+set", 0, 1, 1, 18'h3FFFF);
        chk("R6 pop wins top", top_o, 18'h00001);
    endtask

    task automatic t_wrap();
        do_reset();
        for (int k = 1; k <= 20; k++) step("R8 push", 1, 0, 0, W'(k * 18'h00101));
        for (int k = 19; k >= 4; k--) begin
            step("R8 pop", 0, 1, 0, '0);
            chk("R8 pop order", top_o, W'(k * 18'h00101));
        end
        step("R8 wrap pop", 0, 1, 0, '0);
        chk("R8 overwritten slot", top_o, W'(19 * 18'h00101));
    endtask

    task automatic t_comb_next();
        do_reset();
        step("R9 setup", 1, 0, 0, 18'h0AAAA);
        step("R9 setup", 1, 0, 0, 18'h15555);
        push_i = 1; wr_data_i = 18'h01234;
        @(posedge clk);
        #1;
        push_i = 0;
        chk("R9 next same cycle", next_o, 18'h15555);
        m_ptr = (m_ptr + 1) % D;
        m_slot[m_ptr] = 18'h15555;
        m_vld[m_ptr] = 1'b1;
        m_top = 18'h01234;
    endtask

    initial begin
        t_reset();
        t_push_pop();
        t_replace_idle();
        t_priority();
        t_wrap();
        t_comb_next();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule